// File: doc/BRIEF.md
# Dual-View Peripheral Register Decoder

This block sits between a CPU core and a small bank of peripheral registers. The core reaches the bank in two ways. A short I/O-view address covers 64 locations. A data-view address reaches the same registers shifted up by 0x20. Above the shifted window, an extended region at data addresses 0x60 to 0xFF holds more registers, and only the data view can reach it. A compatibility input turns that whole extended region into 160 bytes of plain storage.

The core can also ask for single-bit set, clear or test on the lowest 32 I/O addresses. Set and clear work as a read-modify-write of the whole register, as a real core would do them. Any write-one-to-clear flag that reads as set is therefore cleared as a side effect. A test returns one condition bit whose sense is chosen per operation. A group of hardware event inputs sets the status flags.

Top module: `regspace_decoder`

## Requirements
- R1: An I/O-view access to address N (0x00 to 0x3F) and a data-view access to address N+0x20 reach the same register. The implemented I/O registers are 0x00 (8-bit read/write), 0x01 (flags in bits 3:0), 0x02 (bits 5:0 read/write) and 0x30 (8-bit read/write).
- R2: Reserved bits read as 0. Writes to reserved locations are ignored and those locations read as 0. Reserved locations are every unlisted I/O address, I/O-view addresses 0x40 and above, and data addresses 0x00 to 0x1F.
- R3: The extended registers are reached only at data-view addresses 0x60 to 0xFF: 0x60 (8-bit) and 0x61 (bits 3:0). An I/O-view access at the same numeric address neither reads nor changes them.
- R4: While `compat_mode` is 1, every data address from 0x60 to 0xFF is a full 8-bit storage byte, and the extended registers keep their contents.
- R5: Writing 1 to a flag bit (register 0x01) clears it. Writing 0 leaves it unchanged.
- R6: `evt_in[k]` sets flag bit k. If the event and a clearing write hit the same bit in the same cycle, the flag ends up set.
- R7: `bit_cmd` 1 (set) or 2 (clear), with an I/O address below 0x20, changes bit `bit_idx` of an ordinary register and leaves its other bits unchanged.
- R8: A bit set or clear on the flag register writes back the whole value it read, with the target bit changed. Every other flag that was set is therefore cleared.
- R9: `bit_cmd` 3 (test) drives `cond_out` to 1 one cycle later exactly when bit `bit_idx` equals `bit_sense`. It changes no state.
- R10: A bit command with an address of 0x20 or above pulses `illegal_out` for one cycle, changes no register and leaves `cond_out` at 0.
- R11: After reset, all registers, `rdata`, `cond_out` and `illegal_out` are 0.
- R12: `rdata` loads the addressed value one cycle after a read with `bit_cmd` 0. It holds its value in cycles without a read. A nonzero `bit_cmd` takes priority and suppresses `rd_en` and `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compat_mode | input | 1 | Turns the extended region into storage bytes |
| data_view | input | 1 | 1: data-view address, 0: I/O-view address |
| addr | input | 8 | Access address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| bit_cmd | input | 2 | 0 none, 1 set, 2 clear, 3 test; address taken as I/O view |
| bit_idx | input | 3 | Bit position for a bit command |
| bit_sense | input | 1 | Bit value that makes a test true |
| evt_in | input | 4 | Hardware events that set flags |
| rdata | output | 8 | Registered read data |
| cond_out | output | 1 | Registered test result |
| illegal_out | output | 1 | Registered illegal bit-command pulse |

## Verification
Every result comes from a register. `rdata`, `cond_out` and `illegal_out` are due one cycle after the edge that accepts the command. A write is visible to a read presented in the next cycle. The bench drives inputs after a falling edge and samples one time unit after the rising edge that accepts the command, before the next edge can change the value. Address sweeps compare each location with an expected value derived from the requirements' address and mask lists.

// File: rtl/regspace_pkg.sv
package regspace_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int IO_AW      = 6;
    localparam int NUM_FLAGS  = 4;

    localparam logic [ADDR_W-1:0] IO_SPAN    = 8'h40;
    localparam logic [ADDR_W-1:0] IO_OFS     = 8'h20;
    localparam logic [ADDR_W-1:0] BIT_LIMIT  = 8'h20;
    localparam logic [ADDR_W-1:0] EXT_BASE   = 8'h60;
    localparam int                EXT_DEPTH  = (1 << ADDR_W) - 8'h60;
    localparam int                EXT_IDX_W  = $clog2(EXT_DEPTH);

    localparam logic [IO_AW-1:0] IO_CTRL = 6'h00;
    localparam logic [IO_AW-1:0] IO_FLAG = 6'h01;
    localparam logic [IO_AW-1:0] IO_TRIM = 6'h02;
    localparam logic [IO_AW-1:0] IO_HIGH = 6'h30;
    localparam logic [ADDR_W-1:0] XA_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] XB_ADDR = 8'h61;

    localparam int TRIM_W = 6;
    localparam int XB_W   = 4;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_SET  = 2'd1,
        BC_CLR  = 2'd2,
        BC_TEST = 2'd3
    } bit_cmd_e;

    typedef enum logic [2:0] {
        T_NONE,
        T_CTRL,
        T_FLAG,
        T_TRIM,
        T_HIGH,
        T_XA,
        T_XB,
        T_STORE
    } target_e;

    typedef struct packed {
        target_e              tgt;
        logic [EXT_IDX_W-1:0] store_idx;
        logic                 bit_bad;
    } decode_t;

    function automatic target_e io_lookup(input logic [IO_AW-1:0] a);
        case (a)
            IO_CTRL: return T_CTRL;
            IO_FLAG: return T_FLAG;
            IO_TRIM: return T_TRIM;
            IO_HIGH: return T_HIGH;
            default: return T_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] bit_mask(input logic [2:0] idx);
        return DATA_W'(1) << idx;
    endfunction

endpackage

// File: rtl/regspace_addr_decode.sv
module regspace_addr_decode
    import regspace_pkg::*;
(
    input  logic              data_view,
    input  logic              compat_mode,
    input  logic              bit_active,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic             io_hit;
    logic [IO_AW-1:0] io_a;

    always_comb begin
        dec           = '0;
        dec.tgt       = T_NONE;
        io_hit        = 1'b0;
        io_a          = addr[IO_AW-1:0];
        if (bit_active) begin
            io_hit      = (addr < BIT_LIMIT);
            dec.bit_bad = !io_hit;
        end else if (!data_view) begin
            io_hit = (addr < IO_SPAN);
        end else if (addr >= EXT_BASE) begin
            if (compat_mode) begin
                dec.tgt       = T_STORE;
                dec.store_idx = EXT_IDX_W'(addr - EXT_BASE);
            end else if (addr == XA_ADDR) begin
                dec.tgt = T_XA;
            end else if (addr == XB_ADDR) begin
                dec.tgt = T_XB;
            end
        end else if (addr >= IO_OFS) begin
            io_hit = 1'b1;
            io_a   = IO_AW'(addr - IO_OFS);
        end
        if (io_hit) begin
            dec.tgt = io_lookup(io_a);
        end
    end
endmodule

// File: rtl/regspace_bitop.sv
module regspace_bitop
    import regspace_pkg::*;
(
    input  bit_cmd_e          cmd,
    input  logic [2:0]        idx,
    input  logic              sense,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] rmw_value,
    output logic              test_hit
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = bit_mask(idx);
        case (cmd)
            BC_SET:  rmw_value = cur | mask;
            BC_CLR:  rmw_value = cur & ~mask;
            default: rmw_value = cur;
        endcase
        test_hit = (cur[idx] == sense);
    end
endmodule

// File: rtl/regspace_store.sv
module regspace_store
    import regspace_pkg::*;
#(
    parameter int DEPTH = EXT_DEPTH,
    parameter int IDX_W = EXT_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (int'(idx) < DEPTH)) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;
endmodule

// File: rtl/regspace_bank.sv
module regspace_bank
    import regspace_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  target_e           tgt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NF-1:0]     evt,
    output logic [DATA_W-1:0] rd_value,
    output logic [NF-1:0]     flag_state
);
    logic [DATA_W-1:0] ctrl_q;
    logic [NF-1:0]     flag_q;
    logic [TRIM_W-1:0] trim_q;
    logic [DATA_W-1:0] high_q;
    logic [DATA_W-1:0] xa_q;
    logic [XB_W-1:0]   xb_q;
    logic [NF-1:0]     clr_mask;

    assign clr_mask = (we && tgt == T_FLAG) ? wdata[NF-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= '0;
            trim_q <= '0;
            high_q <= '0;
            xa_q   <= '0;
            xb_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | evt;
            if (we) begin
                case (tgt)
                    T_CTRL:  ctrl_q <= wdata;
                    T_TRIM:  trim_q <= wdata[TRIM_W-1:0];
                    T_HIGH:  high_q <= wdata;
                    T_XA:    xa_q   <= wdata;
                    T_XB:    xb_q   <= wdata[XB_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (tgt)
            T_CTRL:  rd_value = ctrl_q;
            T_FLAG:  rd_value = DATA_W'(flag_q);
            T_TRIM:  rd_value = DATA_W'(trim_q);
            T_HIGH:  rd_value = high_q;
            T_XA:    rd_value = xa_q;
            T_XB:    rd_value = DATA_W'(xb_q);
            default: rd_value = '0;
        endcase
    end

    assign flag_state = flag_q;
endmodule

// File: rtl/regspace_decoder.sv
module regspace_decoder
    import regspace_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 compat_mode,
    input  logic                 data_view,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [1:0]           bit_cmd,
    input  logic [2:0]           bit_idx,
    input  logic                 bit_sense,
    input  logic [NUM_FLAGS-1:0] evt_in,
    output logic [DATA_W-1:0]    rdata,
    output logic                 cond_out,
    output logic                 illegal_out
);
    bit_cmd_e           cmd;
    decode_t            dec;
    logic [DATA_W-1:0]  bank_rd;
    logic [DATA_W-1:0]  store_rd;
    logic [DATA_W-1:0]  cur_val;
    logic [DATA_W-1:0]  rmw_value;
    logic [DATA_W-1:0]  wr_value;
    logic               test_hit;
    logic               bit_active;
    logic               bit_write;
    logic               do_write;
    logic               do_read;
    logic [NUM_FLAGS-1:0] flag_state;

    assign cmd        = bit_cmd_e'(bit_cmd);
    assign bit_active = (cmd != BC_NONE);

    regspace_addr_decode u_dec (
        .data_view   (data_view),
        .compat_mode (compat_mode),
        .bit_active  (bit_active),
        .addr        (addr),
        .dec         (dec)
    );

    assign cur_val = (dec.tgt == T_STORE) ? store_rd : bank_rd;

    regspace_bitop u_bitop (
        .cmd       (cmd),
        .idx       (bit_idx),
        .sense     (bit_sense),
        .cur       (cur_val),
        .rmw_value (rmw_value),
        .test_hit  (test_hit)
    );

    assign bit_write = (cmd == BC_SET || cmd == BC_CLR) && !dec.bit_bad;
    assign do_write  = bit_active ? bit_write : wr_en;
    assign do_read   = !bit_active && rd_en;
    assign wr_value  = bit_active ? rmw_value : wdata;

    regspace_bank #(.NF(NUM_FLAGS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .we         (do_write && dec.tgt != T_STORE),
        .tgt        (dec.tgt),
        .wdata      (wr_value),
        .evt        (evt_in),
        .rd_value   (bank_rd),
        .flag_state (flag_state)
    );

    regspace_store #(.DEPTH(EXT_DEPTH), .IDX_W(EXT_IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write && dec.tgt == T_STORE),
        .idx   (dec.store_idx),
        .wdata (wr_value),
        .rdata (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            cond_out    <= 1'b0;
            illegal_out <= 1'b0;
        end else begin
            illegal_out <= dec.bit_bad;
            cond_out    <= (cmd == BC_TEST) && !dec.bit_bad && test_hit;
            if (do_read) begin
                rdata <= cur_val;
            end
        end
    end
endmodule

// File: rtl/regspace_checker.sv
module regspace_checker
    import regspace_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 data_view,
    input logic [ADDR_W-1:0]    addr,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wdata,
    input logic [1:0]           bit_cmd,
    input logic [NUM_FLAGS-1:0] evt_in,
    input logic [NUM_FLAGS-1:0] flag_state,
    input logic [DATA_W-1:0]    rdata,
    input logic                 cond_out,
    input logic                 illegal_out
);
    logic flag_hit;
    assign flag_hit = data_view ? (addr == IO_OFS + ADDR_W'(IO_FLAG))
                                : (addr == ADDR_W'(IO_FLAG));

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (rdata == '0 && !cond_out && !illegal_out));

    p_bad_bitop_flagged_r10: assert property (@(posedge clk) disable iff (rst)
        (bit_cmd != 2'd0 && addr >= BIT_LIMIT) |=> illegal_out);

    p_bad_bitop_nocond_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> !cond_out);

    p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((flag_state & $past(evt_in)) == $past(evt_in)));

    p_w1c_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_cmd == 2'd0 && wr_en && flag_hit && evt_in == '0)
        |=> (flag_state == ($past(flag_state) & ~$past(wdata[NUM_FLAGS-1:0]))));

    p_test_no_change_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_cmd == 2'd3 && evt_in == '0) |=> $stable(flag_state));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && bit_cmd == 2'd0) |=> $stable(rdata));
endmodule

bind regspace_decoder regspace_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .data_view   (data_view),
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .bit_cmd     (bit_cmd),
    .evt_in      (evt_in),
    .flag_state  (flag_state),
    .rdata       (rdata),
    .cond_out    (cond_out),
    .illegal_out (illegal_out)
);

// File: tb/regspace_decoder_tb.sv
module regspace_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       compat_mode = 1'b0;
    logic       data_view = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] bit_cmd = '0;
    logic [2:0] bit_idx = '0;
    logic       bit_sense = 1'b0;
    logic [3:0] evt_in = '0;
    logic [7:0] rdata;
    logic       cond_out;
    logic       illegal_out;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regspace_decoder dut_i (
        .clk(clk), .rst(rst), .compat_mode(compat_mode), .data_view(data_view),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .bit_cmd(bit_cmd), .bit_idx(bit_idx), .bit_sense(bit_sense),
        .evt_in(evt_in), .rdata(rdata), .cond_out(cond_out),
        .illegal_out(illegal_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one command cycle; outputs are sampled 1 unit after the accepting edge
    task automatic cyc(input logic dv, input logic [7:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic [1:0] bc, input logic [2:0] bi,
                       input logic bs, input logic [3:0] ev);
        @(negedge clk);
        data_view = dv; addr = a; rd_en = rd; wr_en = wr; wdata = wd;
        bit_cmd = bc; bit_idx = bi; bit_sense = bs; evt_in = ev;
        @(posedge clk);
        #1;
        rd_en = 1'b0; wr_en = 1'b0; bit_cmd = 2'd0; evt_in = '0;
    endtask

    task automatic wr(input logic dv, input logic [7:0] a, input logic [7:0] d);
        cyc(dv, a, 1'b0, 1'b1, d, 2'd0, 3'd0, 1'b0, 4'd0);
    endtask

    task automatic rd(input logic dv, input logic [7:0] a, output logic [7:0] d);
        cyc(dv, a, 1'b1, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 4'd0);
        d = rdata;
    endtask

    task automatic bop(input logic [7:0] a, input logic [1:0] bc, input logic [2:0] bi,
                       input logic bs);
        cyc(1'b0, a, 1'b0, 1'b0, 8'h00, bc, bi, bs, 4'd0);
    endtask

    // implemented-bit mask per I/O address, from R1/R2 (flags handled apart)
    function automatic logic [7:0] io_mask(input int a);
        case (a)
            'h00: return 8'hFF;
            'h02: return 8'h3F;
            'h30: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        logic [7:0] v;
        logic [7:0] ctrl_model;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 rdata reset", rdata, 8'h00);
        chk("R11 cond reset", {7'd0, cond_out}, 8'h00);
        chk("R11 illegal reset", {7'd0, illegal_out}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        rd(1'b1, 8'h21, v);
        chk("R11 flags reset", v, 8'h00);

        // R1/R2: write through I/O view, read through data view
        for (int a = 0; a < 64; a++) begin
            wr(1'b0, 8'(a), 8'(8'hA5 ^ a));
            rd(1'b1, 8'(a + 32), v);
            chk(a == 1 ? "R5 flags unaffected by zero flags" : "R1 io->data view",
                v, 8'(8'hA5 ^ a) & io_mask(a));
        end
        // reverse direction
        for (int a = 0; a < 64; a++) begin
            wr(1'b1, 8'(a + 32), 8'(8'h3C + a));
            rd(1'b0, 8'(a), v);
            chk("R1 data->io view", v, 8'(8'h3C + a) & io_mask(a));
        end
        // R2: data addresses 0x00-0x1F reserved
        for (int a = 0; a < 32; a++) begin
            wr(1'b1, 8'(a), 8'hFF);
            rd(1'b1, 8'(a), v);
            chk("R2 low data reserved", v, 8'h00);
        end

        // R3: extended registers, normal mode
        for (int a = 96; a < 256; a++) begin
            wr(1'b1, 8'(a), 8'(a * 3 + 1));
            rd(1'b1, 8'(a), v);
            chk("R3 extended window", v,
                a == 96 ? 8'(a * 3 + 1) : (a == 97 ? (8'(a * 3 + 1) & 8'h0F) : 8'h00));
        end
        // I/O view at 0x40..0xFF is reserved and cannot reach the extended registers
        for (int a = 64; a < 256; a++) begin
            wr(1'b0, 8'(a), 8'h5A);
            rd(1'b0, 8'(a), v);
            chk("R2 io view out of range", v, 8'h00);
        end
        rd(1'b1, 8'h60, v);
        chk("R3 ext A untouched by io view", v, 8'(96 * 3 + 1));
        rd(1'b1, 8'h61, v);
        chk("R3 ext B untouched by io view", v, 8'(97 * 3 + 1) & 8'h0F);

        // R4: compatibility storage
        compat_mode = 1'b1;
        for (int a = 96; a < 256; a++) wr(1'b1, 8'(a), 8'(a * 7 + 3));
        for (int a = 96; a < 256; a++) begin
            rd(1'b1, 8'(a), v);
            chk("R4 storage byte", v, 8'(a * 7 + 3));
        end
        compat_mode = 1'b0;
        rd(1'b1, 8'h60, v);
        chk("R4 ext A kept", v, 8'(96 * 3 + 1));
        rd(1'b1, 8'h61, v);
        chk("R4 ext B kept", v, 8'(97 * 3 + 1) & 8'h0F);

        // R5/R6: flags
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 4'hF);
        rd(1'b0, 8'h01, v);
        chk("R6 events set flags", v, 8'h0F);
        wr(1'b1, 8'h21, 8'hF5);
        rd(1'b0, 8'h01, v);
        chk("R5 write one clears", v, 8'h0A);
        wr(1'b0, 8'h01, 8'h00);
        rd(1'b0, 8'h01, v);
        chk("R5 write zero keeps", v, 8'h0A);
        cyc(1'b0, 8'h01, 1'b0, 1'b1, 8'h0A, 2'd0, 3'd0, 1'b0, 4'h2);
        rd(1'b0, 8'h01, v);
        chk("R6 set wins over clear", v, 8'h02);

        // R7/R9: bit ops on ordinary register 0x00
        wr(1'b0, 8'h00, 8'h00);
        ctrl_model = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if ((8'h5A >> i) & 1) begin
                bop(8'h00, 2'd1, 3'(i), 1'b0);
                ctrl_model = ctrl_model | (8'h01 << i);
                chk("R7 set no illegal", {7'd0, illegal_out}, 8'h00);
            end
            rd(1'b0, 8'h00, v);
            chk("R7 bit set", v, ctrl_model);
        end
        bop(8'h00, 2'd2, 3'd3, 1'b0);
        rd(1'b1, 8'h20, v);
        chk("R7 bit clear", v, 8'h52);
        bop(8'h00, 2'd1, 3'd3, 1'b0);
        for (int i = 0; i < 8; i++) begin
            bop(8'h00, 2'd3, 3'(i), 1'b1);
            chk("R9 test sense one", {7'd0, cond_out}, 8'((8'h5A >> i) & 1));
            bop(8'h00, 2'd3, 3'(i), 1'b0);
            chk("R9 test sense zero", {7'd0, cond_out}, 8'(~(8'h5A >> i) & 1));
        end
        rd(1'b0, 8'h00, v);
        chk("R9 test leaves register", v, 8'h5A);

        // R8: read-modify-write side effect on flags
        wr(1'b0, 8'h01, 8'h0F);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 4'hB);
        bop(8'h01, 2'd1, 3'd2, 1'b0);
        rd(1'b0, 8'h01, v);
        chk("R8 set clears every set flag", v, 8'h00);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 4'hF);
        bop(8'h01, 2'd2, 3'd1, 1'b0);
        rd(1'b0, 8'h01, v);
        chk("R8 clear keeps only target", v, 8'h02);

        // R10: illegal bit commands
        wr(1'b0, 8'h30, 8'h81);
        bop(8'h30, 2'd1, 3'd1, 1'b0);
        chk("R10 illegal flagged", {7'd0, illegal_out}, 8'h01);
        bop(8'h30, 2'd3, 3'd0, 1'b1);
        chk("R10 illegal pulse", {7'd0, illegal_out}, 8'h01);
        chk("R10 no condition", {7'd0, cond_out}, 8'h00);
        bop(8'h20, 2'd2, 3'd0, 1'b0);
        chk("R10 illegal at 0x20", {7'd0, illegal_out}, 8'h01);
        rd(1'b0, 8'h30, v);
        chk("R10 register unchanged", v, 8'h81);
        chk("R10 pulse ended", {7'd0, illegal_out}, 8'h00);

        // R12: rdata holds, bit command overrides strobes
        rd(1'b0, 8'h30, v);
        wr(1'b0, 8'h00, 8'h11);
        chk("R12 rdata holds", rdata, 8'h81);
        cyc(1'b0, 8'h00, 1'b1, 1'b1, 8'hEE, 2'd3, 3'd0, 1'b1, 4'd0);
        chk("R12 bit cmd blocks read", rdata, 8'h81);
        rd(1'b0, 8'h00, v);
        chk("R12 bit cmd blocks write", v, 8'h11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule